// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a digitally stepped RF attenuator and loads it over a three-wire serial link made of a clock, a data line and a latch strobe. A requester offers an attenuation in half-dB units on a valid/ready handshake. The block saturates the value to the 6-bit range and inverts it, because the attenuator treats a 0 bit as "step engaged". It shifts the word out most significant bit first and then pulses the latch strobe so that the new setting takes effect.

All serial timing comes from counted system-clock cycles. Separate parameters set the clock-high phase, the data-setup phase, the data-hold phase, the gap before the latch and the latch width. At elaboration the block checks each of these against the attenuator's minimum intervals in nanoseconds, given the system clock period. The serial clock idles low, and the data line moves only while the serial clock is low. One word takes 6 × (2·HIGH_CYC + HOLD_CYC) + GAP_CYC + LE_CYC + 1 system cycles from acceptance to the done pulse.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is held, and after it is released, ser_clk, ser_data, ser_le and done are 0 and req_ready is 1.
- R2: An accepted request N in the range 0..63 is sent as the 6-bit bitwise inverse of N. A request of 0 sends 111111, 63 sends 000000, 5 sends 111010 and 42 sends 010101.
- R3: A request above 63 on the REQ_W-bit input is saturated to 63, so it sends 000000.
- R4: Each word produces exactly six rising edges of ser_clk. The attenuator samples ser_data on each rising edge, and the bits arrive most significant first.
- R5: ser_data changes only while ser_clk is low. It is stable for at least HIGH_CYC cycles before each rising edge, and for at least HOLD_CYC cycles after each falling edge.
- R6: Each ser_clk high phase lasts exactly HIGH_CYC cycles. The low phase between two bits of one word lasts exactly HOLD_CYC + HIGH_CYC cycles. ser_clk is high only while a word is in progress.
- R7: After the sixth falling edge, ser_le rises exactly HOLD_CYC + GAP_CYC cycles later and stays high for exactly LE_CYC cycles, with ser_clk low the whole time. There is exactly one ser_le pulse per word.
- R8: req_ready is low from the cycle after acceptance through the done cycle. done is a one-cycle pulse in the cycle right after ser_le falls. A request offered while req_ready is low has no effect on the word being sent and does not start a new one.
- R9: A request that is already valid in the cycle req_ready returns high is accepted on that clock edge, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master can accept a request |
| req_atten | input | REQ_W | Requested attenuation in 0.5 dB units |
| ser_clk | output | 1 | Serial clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch strobe to the attenuator |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a word has been latched |

## Verification
The bench uses the default build: an 8 ns system period, HIGH_CYC=4, HOLD_CYC=2, GAP_CYC=2, LE_CYC=4 and an 8-bit request port. These values give a 12.5 MHz serial clock, and every interval is a handful of cycles, so a one-cycle error in any phase changes a measured run length. The 8-bit request width makes saturating values such as 64 and 200 available as stimulus. The short phases also keep a full word to 67 cycles, which leaves room for back-to-back and busy-time requests.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LSETUP,
        ST_LPULSE,
        ST_DONE
    } mst_state_e;

    typedef enum logic [1:0] {
        SUB_SETUP,
        SUB_HIGH,
        SUB_HOLD
    } bit_sub_e;

    // attenuator serial timing minima, nanoseconds
    localparam int MIN_CLK_HIGH_NS  = 30;
    localparam int MIN_CLK_LOW_NS   = 30;
    localparam int MIN_SETUP_NS     = 10;
    localparam int MIN_HOLD_NS      = 10;
    localparam int MIN_LE_GAP_NS    = 10;
    localparam int MIN_LE_WIDTH_NS  = 30;
    localparam int MIN_CLK_PERIOD_NS = 50;

endpackage

// File: rtl/atten_code_map.sv
module atten_code_map #(
    parameter int REQ_W  = 8,
    parameter int CODE_W = 6
) (
    input  logic [REQ_W-1:0]  req_value,
    output logic [CODE_W-1:0] ctrl_word
);

    localparam int MAX_CODE = (1 << CODE_W) - 1;

    logic [CODE_W-1:0] clamped;

    generate
        if (REQ_W > CODE_W) begin : g_saturate
            always_comb begin
                if (req_value > REQ_W'(MAX_CODE)) begin
                    clamped = CODE_W'(MAX_CODE);
                end else begin
                    clamped = req_value[CODE_W-1:0];
                end
            end
        end else begin : g_passthru
            always_comb begin
                clamped = CODE_W'(req_value);
            end
        end
    endgenerate

    // steps are engaged by a low bit
    assign ctrl_word = ~clamped;

endmodule

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt_q) == '0 && !$past(load)) |-> cnt_q == '0) else $error("timer wrapped"); // R6

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
    import atten_ser_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int REQ_W         = 8,
    parameter int SYS_PERIOD_NS = 8,
    parameter int HIGH_CYC      = 4,
    parameter int HOLD_CYC      = 2,
    parameter int GAP_CYC       = 2,
    parameter int LE_CYC        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [REQ_W-1:0] req_atten,
    output logic             ser_clk,
    output logic             ser_data,
    output logic             ser_le,
    output logic             busy,
    output logic             done
);

    localparam int BIT_W    = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int LONG_A   = (HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC;
    localparam int LONG_B   = (GAP_CYC > LE_CYC) ? GAP_CYC : LE_CYC;
    localparam int LONGEST  = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int CNT_W    = $clog2(LONGEST + 1);

    localparam bit TIMING_OK =
        (HIGH_CYC >= 1) && (HOLD_CYC >= 1) && (GAP_CYC >= 1) && (LE_CYC >= 1) &&
        (HIGH_CYC * SYS_PERIOD_NS >= MIN_CLK_HIGH_NS) &&
        ((HIGH_CYC + HOLD_CYC) * SYS_PERIOD_NS >= MIN_CLK_LOW_NS) &&
        (HIGH_CYC * SYS_PERIOD_NS >= MIN_SETUP_NS) &&
        (HOLD_CYC * SYS_PERIOD_NS >= MIN_HOLD_NS) &&
        ((HOLD_CYC + GAP_CYC) * SYS_PERIOD_NS >= MIN_LE_GAP_NS) &&
        (LE_CYC * SYS_PERIOD_NS >= MIN_LE_WIDTH_NS) &&
        ((2 * HIGH_CYC + HOLD_CYC) * SYS_PERIOD_NS >= MIN_CLK_PERIOD_NS);

    generate
        if (!TIMING_OK) begin : g_timing_violation
            $error("serial phase counts violate attenuator timing minima");
        end
    endgenerate

    typedef struct packed {
        mst_state_e        state;
        bit_sub_e          sub;
        logic [BIT_W-1:0]  bit_idx;
        logic [CODE_W-1:0] shreg;
        logic              sclk;
        logic              sdata;
        logic              sle;
        logic              done;
    } mst_regs_t;

    mst_regs_t r_d, r_q;

    logic [CODE_W-1:0] word_new;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_exp;

    atten_code_map #(
        .REQ_W  (REQ_W),
        .CODE_W (CODE_W)
    ) u_code_map (
        .req_value (req_atten),
        .ctrl_word (word_new)
    );

    atten_phase_timer #(
        .CNT_W (CNT_W)
    ) u_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_len (tmr_len),
        .expired  (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state   = ST_SHIFT;
                    r_d.sub     = SUB_SETUP;
                    r_d.bit_idx = '0;
                    r_d.shreg   = word_new;
                    r_d.sdata   = word_new[CODE_W-1];
                    r_d.sclk    = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_len     = CNT_W'(HIGH_CYC);
                end
            end

            ST_SHIFT: begin
                if (tmr_exp) begin
                    unique case (r_q.sub)
                        SUB_SETUP: begin
                            r_d.sub  = SUB_HIGH;
                            r_d.sclk = 1'b1;
                            tmr_load = 1'b1;
                            tmr_len  = CNT_W'(HIGH_CYC);
                        end
                        SUB_HIGH: begin
                            r_d.sub  = SUB_HOLD;
                            r_d.sclk = 1'b0;
                            tmr_load = 1'b1;
                            tmr_len  = CNT_W'(HOLD_CYC);
                        end
                        default: begin
                            if (r_q.bit_idx == BIT_W'(CODE_W - 1)) begin
                                r_d.state = ST_LSETUP;
                                tmr_load  = 1'b1;
                                tmr_len   = CNT_W'(GAP_CYC);
                            end else begin
                                r_d.bit_idx = r_q.bit_idx + BIT_W'(1);
                                r_d.shreg   = r_q.shreg << 1;
                                r_d.sdata   = r_q.shreg[CODE_W-2];
                                r_d.sub     = SUB_SETUP;
                                tmr_load    = 1'b1;
                                tmr_len     = CNT_W'(HIGH_CYC);
                            end
                        end
                    endcase
                end
            end

            ST_LSETUP: begin
                if (tmr_exp) begin
                    r_d.state = ST_LPULSE;
                    r_d.sle   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(LE_CYC);
                end
            end

            ST_LPULSE: begin
                if (tmr_exp) begin
                    r_d.state = ST_DONE;
                    r_d.sle   = 1'b0;
                    r_d.done  = 1'b1;
                end
            end

            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.sub     <= SUB_SETUP;
            r_q.bit_idx <= '0;
            r_q.shreg   <= '0;
            r_q.sclk    <= 1'b0;
            r_q.sdata   <= 1'b0;
            r_q.sle     <= 1'b0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign busy      = !req_ready;
    assign ser_clk   = r_q.sclk;
    assign ser_data  = r_q.sdata;
    assign ser_le    = r_q.sle;
    assign done      = r_q.done;

    AST_DATA_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data)) else $error("data moved while clock high"); // R5
    AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> busy) else $error("serial clock high while idle"); // R6
    AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk) else $error("latch with clock high"); // R7
    AST_DONE_AFTER_LE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ser_le) && !ser_le)) else $error("done not after latch"); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("ready stayed high"); // R8

endmodule

// File: tb/atten_serial_master_tb.sv
`timescale 1ns/1ps
module atten_serial_master_tb;

    localparam int HIGH = 4;
    localparam int HOLD = 2;
    localparam int GAP  = 2;
    localparam int LEW  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_atten = 8'd0;
    logic       req_ready, ser_clk, ser_data, ser_le, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    atten_serial_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_atten (req_atten),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_le    (ser_le),
        .busy      (busy),
        .done      (done)
    );

    // waveform monitor, sampled on the falling system edge
    int rises, falls, les, hrun, lerun, gap, csf, csd;
    int bad_setup, bad_hold, bad_high, bad_low, chg_high;
    logic [5:0] word;
    bit fall_seen;
    logic prev_clk = 1'b0, prev_data = 1'b0, prev_le = 1'b0;
    int last_wait;

    task automatic mon_clear();
        rises = 0; falls = 0; les = 0; hrun = 0; lerun = 0; gap = -1;
        bad_setup = 0; bad_hold = 0; bad_high = 0; bad_low = 0; chg_high = 0;
        word = '0; fall_seen = 1'b0;
    endtask

    initial begin
        mon_clear();
        csf = 0;
        csd = 100;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            csf = csf + 1;
            csd = csd + 1;
            if (prev_clk && !ser_clk) begin
                falls = falls + 1;
                if (hrun != HIGH) bad_high = bad_high + 1;
                csf = 0;
                fall_seen = 1'b1;
            end
            if (ser_data !== prev_data) begin
                if (ser_clk) chg_high = chg_high + 1;
                if (fall_seen && csf < HOLD) bad_hold = bad_hold + 1;
                csd = 0;
            end
            if (!prev_clk && ser_clk) begin
                rises = rises + 1;
                word = {word[4:0], ser_data};
                if (csd < HIGH) bad_setup = bad_setup + 1;
                if (fall_seen && csf != HIGH + HOLD) bad_low = bad_low + 1;
                hrun = 1;
            end else if (ser_clk) begin
                hrun = hrun + 1;
            end
            if (!prev_le && ser_le) begin
                les = les + 1;
                gap = csf;
                lerun = 0;
            end
            if (ser_le) lerun = lerun + 1;
        end
        prev_clk  = ser_clk;
        prev_data = ser_data;
        prev_le   = ser_le;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offer a request now (at negedge+1), wait for its done pulse, check the waveform
    task automatic run_word(input logic [7:0] atten, input logic [5:0] exp, input string req);
        int waited;
        int guard;
        mon_clear();
        req_atten = atten;
        req_valid = 1'b1;
        waited = 0;
        while (!req_ready) begin
            @(negedge clk); #1;
            waited = waited + 1;
        end
        last_wait = waited;
        @(negedge clk); #1;
        req_valid = 1'b0;
        check(!req_ready, "R8 ready low after accept", req_ready, 0);
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk); #1;
            guard = guard + 1;
        end
        check(word == exp, req, word, exp);
        check(rises == 6, "R4 rising edges", rises, 6);
        check(bad_setup == 0 && bad_hold == 0 && chg_high == 0, "R5 setup/hold",
              bad_setup + bad_hold + chg_high, 0);
        check(bad_high == 0 && bad_low == 0, "R6 clock phases", bad_high + bad_low, 0);
        check(les == 1, "R7 latch pulses", les, 1);
        check(gap == HOLD + GAP, "R7 latch gap", gap, HOLD + GAP);
        check(lerun == LEW, "R7 latch width", lerun, LEW);
        check(done && !req_ready, "R8 ready low in done cycle", req_ready, 0);
        @(negedge clk); #1;
        check(req_ready && !done, "R8 done single, ready back", {req_ready, done}, 2);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!ser_clk && !ser_data && !ser_le && !done, "R1 outputs in reset",
              {ser_clk, ser_data, ser_le, done}, 0);
        check(req_ready, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!ser_clk && !ser_le && req_ready && !busy, "R1 idle after reset",
              {ser_clk, ser_le, req_ready, busy}, 2);
    endtask

    task automatic test_encoding();
        run_word(8'd0,  6'b111111, "R2 request 0");
        run_word(8'd63, 6'b000000, "R2 request 63");
        run_word(8'd5,  6'b111010, "R2 request 5");
        run_word(8'd42, 6'b010101, "R2 request 42");
    endtask

    task automatic test_saturate();
        run_word(8'd64,  6'b000000, "R3 request 64");
        run_word(8'd200, 6'b000000, "R3 request 200");
    endtask

    task automatic test_busy_ignored();
        int guard;
        mon_clear();
        req_atten = 8'd21;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        req_atten = 8'd0;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk); #1;
            guard = guard + 1;
        end
        check(word == 6'b101010, "R8 busy request ignored", word, 6'b101010);
        repeat (30) @(negedge clk);
        #1;
        check(rises == 6 && les == 1 && req_ready, "R8 no extra transfer",
              rises, 6);
    endtask

    task automatic test_back_to_back();
        run_word(8'd10, 6'b110101, "R2 request 10");
        run_word(8'd50, 6'b001101, "R9 back-to-back word");
        check(last_wait == 0, "R9 immediate accept", last_wait, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_encoding();
        test_saturate();
        test_busy_ignored();
        test_back_to_back();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule